// File: doc/BRIEF.md
# Serial ADC Channel Sequencer

This block runs a scan across a list of analog channels on a serial successive-approximation converter. The converter shares one serial clock line and one data-in line with the block and has an active-low chip select. Each conversion is a fixed frame. The block shifts out an 8-bit control word and then gives the converter a few extra clocks to acquire. It then clocks in a 12-bit result, the upper nibble first and the lower byte after it.

Software or a host-side engine first loads a small register file. Slot 0 holds the number of channels to convert. Slots 1 and up hold the raw control entries. A one-cycle start pulse then begins the scan. The block masks each entry down to its channel, gain and polarity bits, and sets the start and external-clock bits itself. It writes each 12-bit result as two bytes, low byte first, into consecutive addresses of a byte-wide result port. A full list of eight entries fills one 16-byte packet. A done pulse marks the end of the scan.

The serial clock is derived from the system clock. The `phase_len` input sets how many system clocks each high phase and each low phase of the serial clock lasts.

Top module: `adc_scan_seq`

## Requirements
- R1: For list slot k, the control word sent is (entry AND 0x7C) OR 0x81: bit 7 and bit 0 are forced to 1, bits 6..2 pass through, and bit 1 is cleared. It goes out MSB first on `adc_din`, one bit per serial clock pulse for the first 8 pulses, and each bit is set up while `adc_sclk` is low.
- R2: `adc_cs_n` falls at least one serial phase before the first rising `adc_sclk` and rises no earlier than the falling edge of the 25th pulse. `adc_sclk` never rises while `adc_cs_n` is high.
- R3: Pulses 9 to 13 of a frame are acquisition pulses. `adc_din` stays 0 throughout them and no data is captured.
- R4: Pulses 14 to 25 capture result bits 11 down to 0, MSB first. `adc_dout` is sampled at the end of each high phase, on the edge where `adc_sclk` falls. Every frame has exactly 25 pulses.
- R5: Every high phase and every low phase of `adc_sclk` during a frame lasts `phase_len`+1 system clocks. This includes the setup phase from the chip-select fall to the first rise.
- R6: Slot 0 holds the channel count N, and values above 8 are treated as 8. Slots 1..N are converted in order. Slot k produces a write of the low result byte at address 2(k-1) and then a write of {4'b0, result[11:8]} at address 2k-1 in the next cycle.
- R7: `done` is a one-cycle pulse in the cycle after the last high-byte write. `busy` is high from the accepted start through that last write and is low whenever `done` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The scan in progress keeps its frame and write count and produces a single `done`.
- R9: With a channel count of 0, a start produces no chip-select or serial clock activity and no writes. `done` appears in the cycle after `start`, and `busy` stays low.
- R10: After a synchronous reset, `adc_cs_n`=1, `adc_sclk`=0, `adc_din`=0, `busy`=0, `done`=0 and `res_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan request |
| phase_len | input | PH_W | System clocks per serial clock phase, minus one |
| cl_we | input | 1 | Channel list write strobe |
| cl_addr | input | CL_AW | Channel list slot (0 = count) |
| cl_wdata | input | 8 | Channel list write data |
| adc_dout | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial data to the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| res_we | output | 1 | Result byte write strobe |
| res_addr | output | RES_AW | Result byte address |
| res_data | output | 8 | Result byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete pulse |

## Verification
A pulse counter that is off by one inside a frame shows up at the chip-select rise of that same frame. The frame ends with other than 25 clocks, or the result comes back shifted and the byte check for that slot fails. A wrong channel index or address base shows up at the first result write as a control word or address that does not match the list slot. Faults in the sequencer state show up within one scan as a missing or doubled `done`, writes with `busy` low, or a restart triggered by a second start pulse.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Frame layout fixed by the converter's serial protocol
    localparam int CTRL_BITS  = 8;
    localparam int ACQ_CLKS   = 5;
    localparam int HI_BITS    = 4;
    localparam int LO_BITS    = 8;
    localparam int RES_BITS   = HI_BITS + LO_BITS;
    localparam int FRAME_CLKS = CTRL_BITS + ACQ_CLKS + RES_BITS;

    localparam logic [CTRL_BITS-1:0] CTRL_KEEP  = 8'h7C;
    localparam logic [CTRL_BITS-1:0] CTRL_FORCE = 8'h81;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_WR_LO,
        SQ_WR_HI
    } seq_state_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } res_word_t;

    function automatic logic [CTRL_BITS-1:0] make_ctrl(input logic [CTRL_BITS-1:0] entry);
        return (entry & CTRL_KEEP) | CTRL_FORCE;
    endfunction

endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PH_W-1:0] phase_len,
    output logic            tick
);

    logic [PH_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt >= phase_len) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt >= phase_len);

    // R5: consecutive phase ends are spaced by phase_len+1 cycles
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && phase_len != '0 && $stable(phase_len)) |=> !tick);

endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
    import adcseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [CTRL_BITS-1:0] ctrl,
    input  logic                 tick,
    input  logic                 adc_dout,
    output logic                 active,
    output logic                 sclk,
    output logic                 din,
    output logic                 cs_n,
    output logic                 res_valid,
    output logic [RES_BITS-1:0]  result
);

    localparam int PW = $clog2(FRAME_CLKS);
    localparam logic [PW-1:0] LAST_P  = PW'(FRAME_CLKS - 1);
    localparam logic [PW-1:0] CAP_P   = PW'(CTRL_BITS + ACQ_CLKS);
    localparam logic [PW-1:0] CTL_END = PW'(CTRL_BITS - 1);

    logic [PW-1:0]        pulse_n;
    logic [CTRL_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            din       <= 1'b0;
            cs_n      <= 1'b1;
            res_valid <= 1'b0;
            result    <= '0;
            pulse_n   <= '0;
            sh        <= '0;
        end else begin
            res_valid <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    din     <= ctrl[CTRL_BITS-1];
                    sh      <= ctrl << 1;
                    pulse_n <= '0;
                    result  <= '0;
                end
            end else if (tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (pulse_n >= CAP_P) begin
                        result <= {result[RES_BITS-2:0], adc_dout};
                    end
                    if (pulse_n == LAST_P) begin
                        active    <= 1'b0;
                        cs_n      <= 1'b1;
                        din       <= 1'b0;
                        res_valid <= 1'b1;
                    end else begin
                        pulse_n <= pulse_n + 1'b1;
                        din     <= (pulse_n < CTL_END) ? sh[CTRL_BITS-1] : 1'b0;
                        sh      <= sh << 1;
                    end
                end
            end
        end
    end

    // R2: the serial clock is only ever high inside a chip-select window
    a_r2_sclk_in_cs: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R3: data-in is low through the acquisition pulses
    a_r3_acq_din_low: assert property (@(posedge clk) disable iff (rst)
        (active && pulse_n > CTL_END && pulse_n < CAP_P) |-> !din);

    // R4: a result is only presented as the chip select is released
    a_r4_valid_at_release: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cs_n && !$past(cs_n)));

    // R5: the serial clock only moves on a divider tick
    a_r5_sclk_on_tick: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> $stable(sclk));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcseq_pkg::*;
#(
    parameter int LIST_DEPTH = 8,
    parameter int PH_W       = 8,
    localparam int CL_AW     = $clog2(LIST_DEPTH + 1),
    localparam int RES_AW    = $clog2(2 * LIST_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PH_W-1:0]   phase_len,
    input  logic              cl_we,
    input  logic [CL_AW-1:0]  cl_addr,
    input  logic [7:0]        cl_wdata,
    input  logic              adc_dout,
    output logic              adc_sclk,
    output logic              adc_din,
    output logic              adc_cs_n,
    output logic              res_we,
    output logic [RES_AW-1:0] res_addr,
    output logic [7:0]        res_data,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(LIST_DEPTH + 1);

    logic [7:0]           clist [LIST_DEPTH+1];
    seq_state_t           state;
    logic [CNT_W-1:0]     idx, last, n_eff;
    logic                 go, tick, f_active, f_valid;
    logic [RES_BITS-1:0]  f_result;
    logic [CTRL_BITS-1:0] ctrl_sel;
    logic [RES_AW-1:0]    base;
    res_word_t            word;

    // channel list register file
    always_ff @(posedge clk) begin
        for (int i = 0; i <= LIST_DEPTH; i++) begin
            if (rst) begin
                clist[i] <= '0;
            end else if (cl_we && cl_addr == CL_AW'(i)) begin
                clist[i] <= cl_wdata;
            end
        end
    end

    always_comb begin
        n_eff    = (clist[0] > 8'(LIST_DEPTH)) ? CNT_W'(LIST_DEPTH) : CNT_W'(clist[0]);
        ctrl_sel = make_ctrl(clist[idx]);
        base     = RES_AW'(idx - 1'b1) << 1;
    end

    adcseq_tick #(.PH_W(PH_W)) tick_i (
        .clk       (clk),
        .rst       (rst),
        .en        (f_active),
        .phase_len (phase_len),
        .tick      (tick)
    );

    adcseq_frame frame_i (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .ctrl      (ctrl_sel),
        .tick      (tick),
        .adc_dout  (adc_dout),
        .active    (f_active),
        .sclk      (adc_sclk),
        .din       (adc_din),
        .cs_n      (adc_cs_n),
        .res_valid (f_valid),
        .result    (f_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            last  <= '0;
            go    <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (n_eff == '0) begin
                            done <= 1'b1;
                        end else begin
                            busy  <= 1'b1;
                            idx   <= CNT_W'(1);
                            last  <= n_eff;
                            go    <= 1'b1;
                            state <= SQ_CONV;
                        end
                    end
                end
                SQ_CONV: begin
                    if (f_valid) begin
                        word.lo <= f_result[LO_BITS-1:0];
                        word.hi <= 8'(f_result[RES_BITS-1:LO_BITS]);
                        state   <= SQ_WR_LO;
                    end
                end
                SQ_WR_LO: state <= SQ_WR_HI;
                SQ_WR_HI: begin
                    if (idx == last) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        go    <= 1'b1;
                        state <= SQ_CONV;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign res_we   = (state == SQ_WR_LO) || (state == SQ_WR_HI);
    assign res_addr = {base[RES_AW-1:1], state == SQ_WR_HI};
    assign res_data = (state == SQ_WR_HI) ? word.hi : word.lo;

    // R6: the high byte follows its low byte at the next address
    a_r6_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
        (res_we && !res_addr[0]) |=> (res_we && res_addr == $past(res_addr) + 1'b1));

    // R7: done and busy never overlap
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: a start during a scan does not move the channel index
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && state == SQ_CONV) |=> (idx == $past(idx)));

    // R9: an empty list completes at once without a frame
    a_r9_empty_list: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && n_eff == '0) |=> (done && !busy && adc_cs_n));

endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
    import adcseq_pkg::*;

    localparam int NV = 5;
    // {count, phase_len, seed}
    localparam logic [23:0] VEC [NV] = '{
        {8'd3, 8'd0, 8'h11},
        {8'd8, 8'd1, 8'h5A},
        {8'd1, 8'd3, 8'hC3},
        {8'd9, 8'd0, 8'h27},
        {8'd5, 8'd2, 8'h90}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, cl_we = 1'b0;
    logic [7:0] phase_len = '0;
    logic [3:0] cl_addr = '0;
    logic [7:0] cl_wdata = '0;
    logic adc_dout, adc_sclk, adc_din, adc_cs_n, res_we, busy, done;
    logic [3:0] res_addr;
    logic [7:0] res_data;

    always #2.5 clk = ~clk;

    adc_scan_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .phase_len(phase_len),
        .cl_we(cl_we), .cl_addr(cl_addr), .cl_wdata(cl_wdata),
        .adc_dout(adc_dout), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_cs_n(adc_cs_n), .res_we(res_we), .res_addr(res_addr),
        .res_data(res_data), .busy(busy), .done(done)
    );

    int checks = 0, failures = 0;
    logic [7:0] entries [9];

    // converter model state
    logic armed = 1'b0;
    int rise_n = 0, frames = 0, pulse_bad = 0, acq_bad = 0, stray = 0;
    logic [7:0] capc = '0;
    logic [11:0] resp = '0;
    logic [7:0] cap_log [16];
    logic dout_r = 1'b0;
    assign adc_dout = dout_r;

    function automatic logic [11:0] fresp(input logic [7:0] c);
        logic [15:0] t;
        t = 16'(c) * 16'd53 + 16'd17;
        return t[11:0] ^ 12'hA5C;
    endfunction

    always @(posedge adc_sclk) begin
        if (armed) begin
            if (adc_cs_n) stray++;
            else begin
                rise_n++;
                if (rise_n <= 8) capc = {capc[6:0], adc_din};
                else if (rise_n <= 13) begin if (adc_din) acq_bad++; end
                if (rise_n == 8) begin
                    resp = fresp(capc);
                    cap_log[frames % 16] = capc;
                end
                if (rise_n >= 14 && rise_n <= 25) dout_r = resp[25 - rise_n];
            end
        end
    end
    always @(negedge adc_cs_n) if (armed) rise_n = 0;
    always @(posedge adc_cs_n) if (armed) begin
        if (rise_n != 25) pulse_bad++;
        frames++;
    end

    // port monitors
    logic [7:0] wbuf [16];
    int wr_cnt = 0, wr_nobusy = 0, done_cnt = 0, order_bad = 0, phase_bad = 0;
    int exp_addr = 0, run = 0, cur_ph = 0;
    logic prev_s = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (armed) begin
            if (res_we) begin
                wbuf[res_addr] = res_data;
                if (int'(res_addr) != exp_addr) order_bad++;
                exp_addr++;
                wr_cnt++;
                if (!busy) wr_nobusy++;
            end
            if (done) done_cnt++;
            if (!adc_cs_n) begin
                if (!prev_cs && adc_sclk == prev_s) run++;
                else begin
                    if (!prev_cs && run != cur_ph + 1) phase_bad++;
                    run = 1;
                end
            end else if (!prev_cs) begin
                if (run != cur_ph + 1) phase_bad++;
            end
            prev_s  = adc_sclk;
            prev_cs = adc_cs_n;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_cnt = 0; wr_nobusy = 0; done_cnt = 0; order_bad = 0; phase_bad = 0;
        frames = 0; pulse_bad = 0; acq_bad = 0; stray = 0; exp_addr = 0;
    endtask

    task automatic load_list(input logic [7:0] cnt, input logic [7:0] seed);
        entries[0] = cnt;
        for (int k = 1; k <= 8; k++) entries[k] = 8'(seed + k * 29);
        for (int k = 0; k <= 8; k++) begin
            @(negedge clk);
            cl_we = 1'b1; cl_addr = 4'(k); cl_wdata = entries[k];
        end
        @(negedge clk);
        cl_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done_cnt > 0) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic run_scan(input logic [7:0] cnt, input logic [7:0] ph, input logic [7:0] seed);
        logic ok;
        int n;
        logic [7:0] ec;
        logic [11:0] er;
        n = (cnt > 8) ? 8 : int'(cnt);
        load_list(cnt, seed);
        phase_len = ph; cur_ph = int'(ph);
        clear_mon();
        pulse_start();
        wait_done(ok);
        chk(ok, "R7 done reached", int'(ok), 1);
        chk(done_cnt == 1, "R7 single done", done_cnt, 1);
        chk(wr_nobusy == 0, "R7 busy during writes", wr_nobusy, 0);
        chk(!busy, "R7 busy low after", int'(busy), 0);
        chk(wr_cnt == 2 * n, "R6 write count", wr_cnt, 2 * n);
        chk(order_bad == 0, "R6 address order", order_bad, 0);
        chk(frames == n, "R2 frame count", frames, n);
        chk(pulse_bad == 0 && stray == 0, "R2 R4 pulses per frame", pulse_bad + stray, 0);
        chk(acq_bad == 0, "R3 acquisition din low", acq_bad, 0);
        chk(phase_bad == 0, "R5 phase length", phase_bad, 0);
        for (int k = 1; k <= n; k++) begin
            ec = (entries[k] & 8'h7C) | 8'h81;
            er = fresp(ec);
            chk(cap_log[k-1] == ec, "R1 control word", int'(cap_log[k-1]), int'(ec));
            chk(wbuf[2*k-2] == er[7:0] && wbuf[2*k-1] == {4'b0, er[11:8]}, "R4 R6 result bytes",
                int'({wbuf[2*k-1], wbuf[2*k-2]}), int'({4'b0, er}));
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic ok;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(adc_cs_n && !adc_sclk && !adc_din && !busy && !done && !res_we, "R10 reset outputs",
            int'({adc_cs_n, adc_sclk, adc_din, busy, done, res_we}), 32);
        armed = 1'b1;

        for (int v = 0; v < NV; v++) run_scan(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

        // R8: second start mid-scan is ignored
        load_list(8'd2, 8'h33);
        phase_len = 8'd1; cur_ph = 1;
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        chk(busy, "R8 busy mid-scan", int'(busy), 1);
        pulse_start();
        wait_done(ok);
        chk(wr_cnt == 4, "R8 write count", wr_cnt, 4);
        chk(frames == 2, "R8 frame count", frames, 2);
        chk(done_cnt == 1, "R8 single done", done_cnt, 1);

        // R9: empty list
        load_list(8'd0, 8'h01);
        clear_mon();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R9 done next cycle", int'({done, busy}), 2);
        repeat (100) @(negedge clk);
        chk(frames == 0 && stray == 0 && adc_cs_n, "R9 no serial activity", frames + stray, 0);
        chk(wr_cnt == 0, "R9 no writes", wr_cnt, 0);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);

        finish_run();
    end

endmodule